// File: doc/BRIEF.md
# Serial Byte Receiver with Bounded Start Search

This block receives one asynchronous serial character: one start bit, eight data bits and one stop bit, with no parity. It has no free-running listening mode. A one-cycle request pulse on `arm` opens a search for a start bit, and that search has a fixed time budget. When a falling level appears on the line, the block waits half a bit period and samples the line again. If the line is back high, the low was only a glitch and the search continues. A confirmed start is followed by eight data samples, one bit period apart and taken at bit centres, and then by one stop-bit sample.

Each request ends with a single `done` pulse. `ok` goes with a good character, which is then presented on `rx_byte`. `err` goes with a search that ran out of time or a stop bit sampled low. The line input must already be synchronised to `clk`. The bit period is computed from the clock frequency and the baud rate. At the default settings of 9600 baud, a bit period is close to 104 us and the search budget is 49 bit periods, about 5.1 ms.

Top module: `uart_rx_hunt`

## Requirements
- R1: After reset `done`, `ok`, `err` are 0 and `rx_byte` is 0x00; with no request accepted, line activity never produces `done`.
- R2: A high `arm` in the idle state starts a search; `arm` while a request is in progress is ignored (the running reception completes normally and only one `done` results).
- R3: A low line seen while searching is re-sampled BIT_TICKS/2 cycles later; if it is high then, the start is rejected and the search resumes.
- R4: Data bits are sampled every BIT_TICKS cycles after the confirmed start sample and assembled least significant bit first (first data bit lands in `rx_byte[0]`).
- R5: The stop bit is sampled BIT_TICKS cycles after the eighth data bit; high gives `ok`, low gives `err`.
- R6: With BIT_TICKS = CLK_HZ/BAUD and HUNT_TICKS = BIT_TICKS*HUNT_BITS, a search with the line held high ends with `done` and `err` exactly HUNT_TICKS cycles after the cycle in which `arm` was taken.
- R7: Search time already spent is kept across a rejected start: the time spent confirming is not counted, so a search holding one short glitch still fails HUNT_TICKS + BIT_TICKS/2 + 1 cycles after `arm`.
- R8: `done` is a one-cycle pulse; exactly one of `ok`/`err` is high with it, and both are low when `done` is low.
- R9: `rx_byte` changes only in the cycle where `done` and `ok` are both high; on an error it keeps the last good character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Request pulse: start one search and reception |
| rx_line | input | 1 | Synchronised serial line, idles high |
| rx_byte | output | 8 | Last correctly received character |
| done | output | 1 | One-cycle end-of-request pulse |
| ok | output | 1 | With `done`: character received with a high stop bit |
| err | output | 1 | With `done`: search timed out or stop bit low |

## Verification
A wrong sample phase or a miscounted bit index shows up on `rx_byte` as a shifted or corrupted character, and it is visible in the `done` cycle of that same frame. If the search counter were cleared at the wrong moment, the timeout `done` would arrive a measurable number of cycles early or late, so both timeout paths are checked to the exact cycle. If a state failed to return to idle, or a request restarted while busy, a second or a missing `done` would appear within one search budget after the frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HUNT    = 3'd1,
    ST_CONFIRM = 3'd2,
    ST_DATA    = 3'd3,
    ST_STOP    = 3'd4
  } rx_state_t;
endpackage

// File: rtl/rx_bit_timer.sv
// Bit-period counter with half-period and full-period terminal flags.
module rx_bit_timer #(
  parameter int BIT_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic half_hit,
  output logic full_hit
);
  localparam int HALF_TICKS = BIT_TICKS / 2;
  localparam int CW = $clog2(BIT_TICKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign half_hit = (cnt == CW'(HALF_TICKS - 1));
  assign full_hit = (cnt == CW'(BIT_TICKS - 1));
endmodule

// File: rtl/rx_hunt_timer.sv
// Accumulates cycles spent searching with the line high; not cleared by a rejected start.
module rx_hunt_timer #(
  parameter int HUNT_TICKS = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int HW = $clog2(HUNT_TICKS + 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == HW'(HUNT_TICKS - 1));
endmodule

// File: rtl/rx_shift.sv
// LSB-first data assembly with a bit index.
module rx_shift #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [DATA_BITS-1:0] q,
  output logic                 last_bit
);
  localparam int IW = $clog2(DATA_BITS + 1);

  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx <= '0;
    end else if (shift_en) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {bit_in, q[DATA_BITS-1:1]};
    end
  end

  assign last_bit = (idx == IW'(DATA_BITS - 1));
endmodule

// File: rtl/uart_rx_hunt.sv
module uart_rx_hunt
  import uart_rx_pkg::*;
#(
  parameter int CLK_HZ    = 200_000_000,
  parameter int BAUD      = 9600,
  parameter int HUNT_BITS = 49,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 arm,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 done,
  output logic                 ok,
  output logic                 err
);
  localparam int BIT_TICKS  = CLK_HZ / BAUD;
  localparam int HUNT_TICKS = BIT_TICKS * HUNT_BITS;

  rx_state_t state;
  logic half_hit, full_hit, hunt_out, last_bit;
  logic tmr_clr, hunt_clr, hunt_en, sh_clr, sh_en;
  logic [DATA_BITS-1:0] shreg;

  always_comb begin
    tmr_clr = 1'b0;
    unique case (state)
      ST_IDLE, ST_HUNT: tmr_clr = 1'b1;
      ST_CONFIRM:       tmr_clr = half_hit;
      ST_DATA, ST_STOP: tmr_clr = full_hit;
      default:          tmr_clr = 1'b1;
    endcase
  end

  assign hunt_clr = (state == ST_IDLE);
  assign hunt_en  = (state == ST_HUNT) && rx_line;
  assign sh_clr   = (state == ST_CONFIRM);
  assign sh_en    = (state == ST_DATA) && full_hit;

  rx_bit_timer #(.BIT_TICKS(BIT_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr),
    .half_hit(half_hit), .full_hit(full_hit)
  );

  rx_hunt_timer #(.HUNT_TICKS(HUNT_TICKS)) u_hunt (
    .clk(clk), .rst(rst), .clr(hunt_clr), .en(hunt_en), .expired(hunt_out)
  );

  rx_shift #(.DATA_BITS(DATA_BITS)) u_sh (
    .clk(clk), .rst(rst), .clr(sh_clr), .shift_en(sh_en),
    .bit_in(rx_line), .q(shreg), .last_bit(last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      ok      <= 1'b0;
      err     <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      ok   <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (arm) state <= ST_HUNT;
        end
        ST_HUNT: begin
          if (!rx_line) begin
            state <= ST_CONFIRM;
          end else if (hunt_out) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            err   <= 1'b1;
          end
        end
        ST_CONFIRM: begin
          if (half_hit) state <= rx_line ? ST_HUNT : ST_DATA;
        end
        ST_DATA: begin
          if (full_hit && last_bit) state <= ST_STOP;
        end
        ST_STOP: begin
          if (full_hit) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            ok    <= rx_line;
            err   <= !rx_line;
            if (rx_line) rx_byte <= shreg;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_hunt_chk.sv
module uart_rx_hunt_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 arm,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 done,
  input logic                 ok,
  input logic                 err
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (done) pend <= 1'b0;
    else if (arm)  pend <= 1'b1;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    done |-> (ok ^ err)); // R8

  AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!ok && !err)); // R8

  AST_BYTE_ONLY_ON_OK: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_byte) |-> (done && ok)); // R9

  AST_DONE_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    done |-> pend); // R2
endmodule

bind uart_rx_hunt uart_rx_hunt_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .arm(arm), .rx_byte(rx_byte),
  .done(done), .ok(ok), .err(err)
);

// File: tb/sim_uart_rx_hunt.sv
`timescale 1ns/1ps
module sim_uart_rx_hunt;
  localparam int CLK_HZ    = 1_600_000;
  localparam int BAUD      = 100_000;
  localparam int HUNT_BITS = 10;
  localparam int BT   = CLK_HZ / BAUD;
  localparam int HALF = BT / 2;
  localparam int HT   = BT * HUNT_BITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic rx  = 1'b1;
  logic [7:0] rx_byte;
  logic done, ok, err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] last_good = 8'h00;
  int cyc;
  logic got_ok, got_err;
  logic [7:0] got_byte;

  always #2.5 clk = ~clk;

  uart_rx_hunt #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .HUNT_BITS(HUNT_BITS)) u0 (
    .clk(clk), .rst(rst), .arm(arm), .rx_line(rx),
    .rx_byte(rx_byte), .done(done), .ok(ok), .err(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  // cycles counted from the edge that took arm; leaves result in cyc/got_*
  task automatic wait_done(input int limit);
    cyc = 0;
    got_ok = 1'b0; got_err = 1'b0;
    while (cyc <= limit) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
    got_ok = ok; got_err = err; got_byte = rx_byte;
    if (done) begin
      @(negedge clk);
      chk("R8 done low next cycle", int'(done), 0);
      chk("R8 verdicts low next cycle", int'(ok | err), 0);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_v, input int gap);
    repeat (gap) @(negedge clk);
    rx = 1'b0;
    repeat (BT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BT) @(negedge clk);
    end
    rx = stop_v;
    repeat (BT) @(negedge clk);
    rx = 1'b1;
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] b, input logic stop_v);
    return stop_v ? b : last_good;
  endfunction

  task automatic run_frame(input logic [7:0] b, input logic stop_v, input int gap);
    fork
      begin pulse_arm(); wait_done(HT + 20 * BT); end
      send_frame(b, stop_v, gap + 2);
    join
    chk("R5 ok flag", int'(got_ok), int'(stop_v));
    chk("R5 err flag", int'(got_err), int'(!stop_v));
    chk(stop_v ? "R4 data LSB first" : "R9 byte held on error",
        int'(got_byte), int'(exp_byte(b, stop_v)));
    if (stop_v) last_good = b;
  endtask

  task automatic count_dones(input int span, output int cnt);
    cnt = 0;
    repeat (span) begin
      @(negedge clk);
      if (done) cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd2417));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset ok", int'(ok), 0);
    chk("R1 reset err", int'(err), 0);
    chk("R1 reset byte", int'(rx_byte), 0);

    // R1: line activity without request
    fork
      send_frame(8'h5A, 1'b1, 3);
      count_dones(12 * BT, cnt);
    join
    chk("R1 no done without arm", cnt, 0);
    chk("R1 byte untouched", int'(rx_byte), 0);

    // R6: plain timeout, line high
    pulse_arm();
    wait_done(2 * HT);
    chk("R6 timeout cycle", cyc, HT);
    chk("R6 timeout err", int'(got_err), 1);

    // R3/R7: short glitch rejected, hunt time kept
    fork
      begin pulse_arm(); wait_done(3 * HT); end
      begin repeat (100) @(negedge clk); rx = 1'b0; repeat (3) @(negedge clk); rx = 1'b1; end
    join
    chk("R7 timeout with false start", cyc, HT + HALF + 1);
    chk("R3 false start gives err", int'(got_err), 1);

    // R3: glitch then real frame
    fork
      begin pulse_arm(); wait_done(HT + 20 * BT); end
      begin
        repeat (10) @(negedge clk); rx = 1'b0; repeat (2) @(negedge clk); rx = 1'b1;
        send_frame(8'hC3, 1'b1, 20);
      end
    join
    chk("R3 frame after glitch ok", int'(got_ok), 1);
    chk("R3 frame after glitch byte", int'(got_byte), 8'hC3);
    last_good = 8'hC3;

    // directed corners
    run_frame(8'h00, 1'b1, 0);
    run_frame(8'hFF, 1'b1, 5);
    run_frame(8'h01, 1'b1, 9);
    run_frame(8'h80, 1'b1, 1);
    run_frame(8'hA5, 1'b0, 4);

    // R2: arm during reception ignored
    fork
      begin pulse_arm(); wait_done(HT + 20 * BT); end
      send_frame(8'h3C, 1'b1, 6);
      begin repeat (70) @(negedge clk); arm = 1'b1; @(negedge clk); arm = 1'b0; end
    join
    chk("R2 busy arm frame byte", int'(got_byte), 8'h3C);
    last_good = 8'h3C;
    count_dones(HT + 4 * BT, cnt);
    chk("R2 no extra done", cnt, 0);

    // random frames
    for (int k = 0; k < 24; k++) begin
      logic [7:0] b;
      logic s;
      b = 8'($urandom);
      s = ($urandom % 4) != 0;
      run_frame(b, s, int'($urandom % 100));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule